// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Register

This block converts a parallel word into a serial bit stream. A chain of stages can be filled at once from a parallel data bus. On each shift request the chain moves one position toward its last stage, and a serial input fills the first stage. The last stage drives a true serial output and a complemented serial output.

The shift request comes from two external lines that do the same job: a shift clock and a clock-inhibit. The two lines are combined by OR into one gated clock. A shift happens on a rising edge of that gated clock, so either line can produce the edge while the other stays low, and either line held high blocks the other.

All state runs on a fast free-running system clock. The two external lines are treated as asynchronous data: each passes through a synchronizer, and the rising edge is detected in the system-clock domain. A low level on the active-low load input overrides everything else and copies the parallel bus into the stages on every system-clock edge.

Top module: `psr_shifter`

## Requirements
- R1: A synchronous active-high reset clears every stage, the synchronizers and the edge history to 0. After reset `q_out` reads 0 and `q_out_n` reads 1.
- R2: On each system-clock edge where `shift_ld_n` is low, stage i takes `par_in[i]`, whatever the levels of `sclk_in`, `sinh_in` and `ser_in`. `par_in[0]` feeds the first stage. `par_in[WIDTH-1]` feeds the last stage, which drives `q_out`.
- R3: With `shift_ld_n` high and `sinh_in` low, a rising edge on `sclk_in` causes exactly one shift. The shift takes effect on the third system-clock edge after the input change: two synchronizer edges, then the register edge.
- R4: With `shift_ld_n` high and `sclk_in` low, a rising edge on `sinh_in` causes exactly one shift, with the same latency as R3.
- R5: While either of `sclk_in` and `sinh_in` is high, transitions on the other cause no shift, and all stages hold their contents.
- R6: On a shift, the first stage takes `ser_in` as sampled on the register edge, and every other stage takes the previous contents of the stage before it.
- R7: `q_out_n` is always the inverse of `q_out`.
- R8: If `sclk_in` and `sinh_in` rise together in the same sampled cycle, exactly one shift results.
- R9: When `shift_ld_n` returns high while the gated clock is already high, no shift occurs. Only a later rising edge of the gated clock shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_ld_n | input | 1 | Low: parallel load; high: shift mode |
| sclk_in | input | 1 | Asynchronous shift clock |
| sinh_in | input | 1 | Asynchronous clock-inhibit line, interchangeable with the shift clock |
| ser_in | input | 1 | Serial data into the first stage |
| par_in | input | WIDTH | Parallel load data; bit 0 goes to the first stage |
| q_out | output | 1 | Last stage, true serial output |
| q_out_n | output | 1 | Last stage, complemented serial output |

## Verification
The bench builds the block with its defaults: WIDTH=8 and SYNC_STAGES=2. With these values a loaded word drains out of the serial output within eight shifts, so every stage, and the serial bits that refill them, becomes visible at the ports. The two-stage synchronizer fixes the shift latency at three system-clock edges. The bench's reference model can therefore compare outputs cycle by cycle in every test: edges from either line, inhibited clocking, simultaneous rises, and a load released while the gated clock is high.

// File: rtl/psr_pkg.sv
package psr_pkg;

    // Action applied to the stage chain on a system-clock edge
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_SHIFT = 2'd2
    } psr_mode_e;

endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign q_o = s_q.chain[STAGES-1];

endmodule

// File: rtl/psr_gate_edge.sv
module psr_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic a_i,
    input  logic b_i,
    output logic fire_o
);

    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t e_d, e_q;
    logic  gate;

    always_comb begin
        gate   = a_i | b_i;
        fire_o = gate & ~e_q.prev;
        e_d    = e_q;
        // History always tracks the gated clock, also during load,
        // so ending a load never produces a false edge.
        e_d.prev = gate;
    end

    always_ff @(posedge clk) begin
        if (rst) e_q <= '0;
        else     e_q <= e_d;
    end

    // R8: a detected edge is one cycle wide, so one rise gives one shift
    a_r8_single_fire: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !fire_o);

endmodule

// File: rtl/psr_stages.sv
module psr_stages
    import psr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  psr_mode_e    mode_i,
    input  logic [W-1:0] par_i,
    input  logic         ser_i,
    output logic [W-1:0] st_o
);

    typedef struct packed {
        logic [W-1:0] st;
    } stage_t;

    stage_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (mode_i)
            MODE_LOAD:  r_d.st = par_i;
            MODE_SHIFT: r_d.st = {r_q.st[W-2:0], ser_i};
            default:    r_d.st = r_q.st;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign st_o = r_q.st;

    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_LOAD) |=> (st_o == $past(par_i)));

    a_r6_shift: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_SHIFT) |=> (st_o == {$past(st_o[W-2:0]), $past(ser_i)}));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_HOLD) |=> $stable(st_o));

endmodule

// File: rtl/psr_shifter.sv
module psr_shifter
    import psr_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_ld_n,
    input  logic             sclk_in,
    input  logic             sinh_in,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             q_out,
    output logic             q_out_n
);

    localparam int LAST = WIDTH - 1;

    logic [1:0]       raw_lines;
    logic [1:0]       sync_lines;
    logic             fire;
    psr_mode_e        mode;
    logic [WIDTH-1:0] stages;

    assign raw_lines = {sinh_in, sclk_in};

    psr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_lines),
        .q_o (sync_lines)
    );

    psr_gate_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .a_i    (sync_lines[0]),
        .b_i    (sync_lines[1]),
        .fire_o (fire)
    );

    always_comb begin
        if (!shift_ld_n) mode = MODE_LOAD;
        else if (fire)   mode = MODE_SHIFT;
        else             mode = MODE_HOLD;
    end

    psr_stages #(.W(WIDTH)) u_stages (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .par_i  (par_in),
        .ser_i  (ser_in),
        .st_o   (stages)
    );

    assign q_out   = stages[LAST];
    assign q_out_n = ~stages[LAST];

    // R9: the first edge of shift mode never shifts if the gated clock stayed high
    a_r9_release_quiet: assert property (@(posedge clk) disable iff (rst)
        ($rose(shift_ld_n) && $past(sync_lines != 2'b00) && (sync_lines != 2'b00))
        |-> (mode == MODE_HOLD));

endmodule

// File: tb/psr_shifter_test.sv
module psr_shifter_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         shift_ld_n;
    logic         sclk_in;
    logic         sinh_in;
    logic         ser_in;
    logic [W-1:0] par_in;
    logic         q_out;
    logic         q_out_n;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // reference state
    logic         m_c1, m_c2, m_i1, m_i2, m_prev;
    logic [W-1:0] m_reg;

    always #5 clk = ~clk;

    psr_shifter uut (
        .clk        (clk),
        .rst        (rst),
        .shift_ld_n (shift_ld_n),
        .sclk_in    (sclk_in),
        .sinh_in    (sinh_in),
        .ser_in     (ser_in),
        .par_in     (par_in),
        .q_out      (q_out),
        .q_out_n    (q_out_n)
    );

    function automatic logic [W-1:0] next_reg(input logic ld_n, input logic fire,
                                              input logic [W-1:0] cur, input logic [W-1:0] par,
                                              input logic ser);
        if (!ld_n)     return par;
        else if (fire) return {cur[W-2:0], ser};
        else           return cur;
    endfunction

    task automatic model_edge();
        logic gate;
        gate = m_c2 | m_i2;
        if (rst) begin
            m_c1 = 0; m_c2 = 0; m_i1 = 0; m_i2 = 0; m_prev = 0; m_reg = '0;
        end else begin
            m_reg  = next_reg(shift_ld_n, gate & ~m_prev, m_reg, par_in, ser_in);
            m_prev = gate;
            m_c2 = m_c1; m_c1 = sclk_in;
            m_i2 = m_i1; m_i1 = sinh_in;
        end
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // one system-clock edge, then compare both outputs at the falling edge
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, q_out, m_reg[W-1]);
        check("R7", q_out_n, ~m_reg[W-1]);
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        rst = 1; shift_ld_n = 1; sclk_in = 0; sinh_in = 0; ser_in = 0; par_in = '0;
        m_c1 = 0; m_c2 = 0; m_i1 = 0; m_i2 = 0; m_prev = 0; m_reg = '0;
        void'($urandom(32'd4711));
        steps(2, "R1");
        check("R1 q_out", q_out, 1'b0);
        check("R1 q_out_n", q_out_n, 1'b1);
        rst = 0;

        // R2: load overrides clock activity and serial input
        par_in = 8'b1010_0110; shift_ld_n = 0; ser_in = 1;
        sclk_in = 1; step("R2"); sclk_in = 0; step("R2"); sinh_in = 1; step("R2");
        sinh_in = 0; steps(3, "R2");
        check("R2 last stage", q_out, 1'b1);
        shift_ld_n = 1;
        steps(3, "R2");

        // R3: edges from the shift clock, exact latency
        ser_in = 0;
        sclk_in = 1; step("R3"); step("R3");
        check("R3 no early shift", q_out, 1'b1);
        step("R3");
        check("R3 shifted", q_out, 1'b0);
        sclk_in = 0; steps(3, "R3");

        // R4: edges from the inhibit line while the clock is low
        ser_in = 1;
        sinh_in = 1; steps(4, "R4");
        check("R4 shifted", q_out, 1'b1);
        sinh_in = 0; steps(3, "R4");

        // R5: inhibit high blocks clock transitions
        sinh_in = 1; steps(4, "R5");
        for (int k = 0; k < 4; k++) begin
            sclk_in = ~sclk_in; steps(3, "R5");
        end
        sinh_in = 0; sclk_in = 0; steps(4, "R5");

        // R8: simultaneous rise counts once
        par_in = 8'b1100_0000; shift_ld_n = 0; step("R8"); shift_ld_n = 1; ser_in = 0;
        steps(3, "R8");
        sclk_in = 1; sinh_in = 1; steps(4, "R8");
        check("R8 one shift", q_out, 1'b1);
        sclk_in = 0; sinh_in = 0; steps(4, "R8");
        sclk_in = 1; steps(4, "R8");
        check("R8 second shift", q_out, 1'b0);

        // R9: load released while gated clock already high
        par_in = 8'b1000_0000; shift_ld_n = 0; steps(4, "R9");
        shift_ld_n = 1; steps(4, "R9");
        check("R9 no spurious shift", q_out, 1'b1);
        sclk_in = 0; steps(4, "R9");

        // R6: random mix against the reference model
        for (int n = 0; n < 3000; n++) begin
            shift_ld_n = ($urandom % 10) != 0;
            if (($urandom % 4) == 0) sclk_in = ~sclk_in;
            if (($urandom % 6) == 0) sinh_in = ~sinh_in;
            ser_in = $urandom;
            par_in = $urandom;
            step("R6");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule